// File: doc/BRIEF.md
# Serial-loaded multichannel DAC code register bank

This block holds the fourteen-bit output codes for a bank of 32 converter channels and loads them from a three-wire serial link. The three lines are a frame sync (active low), a serial clock and a data line. All three are sampled by a faster system clock, at least four times the serial clock rate. Edges are detected on the sampled copies. Each write frame carries a channel address and a code. When the frame is complete, the code lands in the addressed channel register.

A frame begins only on a falling edge of the frame sync. The frame ends after a fixed count of bits has been taken, not when sync returns high. Further sync edges are ignored while a frame is still short of bits. Extra serial clocks are ignored after the frame is full. The serial clock may run continuously or only during transfers.

Each completed frame produces a one-cycle update strobe that carries the channel number and the code. The update output is valid-only, with no ready. The serial link has no way to stall, so the consumer must accept the strobe in the cycle it is shown. Frames are at least 19 serial clocks apart, so consecutive strobes are separated by many cycles. A combinational read port returns the stored code of any channel.

Top module: `dacbank_top`

## Requirements
- R1: While rst_n is low, and after it is released, all 32 channel codes read as zero and upd_valid is low.
- R2: A frame is 19 bits, sent MSB first. The first five bits are the channel address, with the first bit as the address MSB. The next fourteen bits are the code, MSB first. Each bit is taken from sdi_in at a falling edge of sck_in.
- R3: After a frame completes, the read port returns the new code for the addressed channel. All other channels keep their codes.
- R4: Every completed frame gives exactly one upd_valid pulse, one system cycle wide. The pulse comes the cycle after the 19th bit is taken, and upd_chan/upd_code carry the written channel and code.
- R5: Bits are counted only after a falling edge of fs_n_in. Serial clocks that arrive with no armed frame are ignored, including those after reset and before the first falling sync edge.
- R6: While a frame holds fewer than 19 bits, rising and falling edges of fs_n_in are ignored. The bit count continues and the frame completes with its original bits.
- R7: Once 19 bits have been taken, further sck_in falling edges are ignored until the next falling edge of fs_n_in. No second write or strobe is produced.
- R8: Frames load correctly with a serial clock that idles between transfers. They also load correctly with a serial clock that keeps toggling before and after a frame.
- R9: The read port is combinational: rd_code follows rd_chan in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low reset, clears all codes and state |
| fs_n_in | input | 1 | Frame sync, active low, asynchronous |
| sck_in | input | 1 | Serial clock, asynchronous |
| sdi_in | input | 1 | Serial data, taken at sck_in falling edges |
| rd_chan | input | 5 | Read port channel index |
| rd_code | output | 14 | Stored code of channel rd_chan |
| upd_valid | output | 1 | One-cycle update strobe, no back-pressure |
| upd_chan | output | 5 | Channel written, valid with upd_valid |
| upd_code | output | 14 | Code written, valid with upd_valid |

## Verification
A wrong bit count or a mis-armed frame shows at the ports in one of two ways. A strobe can be missing or extra. A code can be shifted by one or more bit positions, so the stored value and upd_code differ from the expected word. Both are visible within a few system cycles of the last falling serial clock of the frame. A wrong write-enable decode shows as a changed code on a channel that was not addressed. Each frame is followed by a readback of the whole bank, so such an error is found before the next frame. A stuck-armed or stuck-idle interface shows as a missing strobe after the next frame, or as an unexpected strobe from serial clocks sent without a falling sync edge.

// File: rtl/dacbank_pkg.sv
package dacbank_pkg;
  localparam int NUM_CH     = 32;
  localparam int CODE_W     = 14;
  localparam int ADDR_W     = $clog2(NUM_CH);
  localparam int FRAME_BITS = ADDR_W + CODE_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);

  typedef struct packed {
    logic [ADDR_W-1:0] chan;
    logic [CODE_W-1:0] code;
  } dac_word_t;
endpackage

// File: rtl/dacbank_sync.sv
module dacbank_sync #(
  parameter int          W       = 3,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out,
  output logic [W-1:0] prev_out
);
  // Two flops per line bring it into the clk domain; a third holds the
  // previous synchronized sample for edge detection.
  for (genvar i = 0; i < W; i++) begin : g_line
    logic s1, s2, s3;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= RST_VAL[i];
        s2 <= RST_VAL[i];
        s3 <= RST_VAL[i];
      end else begin
        s1 <= async_in[i];
        s2 <= s1;
        s3 <= s2;
      end
    end
    assign sync_out[i] = s2;
    assign prev_out[i] = s3;
  end
endmodule

// File: rtl/dacbank_frame_rx.sv
module dacbank_frame_rx
  import dacbank_pkg::*;
#(
  parameter int A_W = ADDR_W,
  parameter int C_W = CODE_W,
  localparam int N_BITS = A_W + C_W,
  localparam int N_CW   = $clog2(N_BITS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fs_fall,
  input  logic            sck_fall,
  input  logic            sdi,
  output logic            armed,
  output logic [N_CW-1:0] bit_cnt,
  output logic            frm_valid,
  output logic [A_W-1:0]  frm_chan,
  output logic [C_W-1:0]  frm_code
);
  logic [N_BITS-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      bit_cnt   <= '0;
      shreg     <= '0;
      frm_valid <= 1'b0;
    end else begin
      frm_valid <= 1'b0;
      if (!armed) begin
        // Idle: only a falling sync edge starts a frame; clocks are dropped.
        if (fs_fall) begin
          armed   <= 1'b1;
          bit_cnt <= '0;
        end
      end else if (sck_fall) begin
        // Armed: sync edges are ignored, bits counted until the frame is full.
        shreg <= {shreg[N_BITS-2:0], sdi};
        if (bit_cnt == N_CW'(N_BITS - 1)) begin
          armed     <= 1'b0;
          bit_cnt   <= '0;
          frm_valid <= 1'b1;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

  assign frm_chan = shreg[N_BITS-1:C_W];
  assign frm_code = shreg[C_W-1:0];
endmodule

// File: rtl/dacbank_code_bank.sv
module dacbank_code_bank #(
  parameter int N_CH = 32,
  parameter int C_W  = 14,
  localparam int A_W = $clog2(N_CH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [A_W-1:0] wr_chan,
  input  logic [C_W-1:0] wr_code,
  input  logic [A_W-1:0] rd_chan,
  output logic [C_W-1:0] rd_code
);
  logic [C_W-1:0] codes [N_CH];

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        codes[c] <= '0;
      else if (wr_en && wr_chan == A_W'(c))
        codes[c] <= wr_code;
    end
  end

  assign rd_code = codes[rd_chan];
endmodule

// File: rtl/dacbank_top.sv
module dacbank_top
  import dacbank_pkg::*;
#(
  parameter int N_CH = NUM_CH,
  parameter int C_W  = CODE_W,
  localparam int A_W  = $clog2(N_CH),
  localparam int N_CW = $clog2(A_W + C_W + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fs_n_in,
  input  logic           sck_in,
  input  logic           sdi_in,
  input  logic [A_W-1:0] rd_chan,
  output logic [C_W-1:0] rd_code,
  output logic           upd_valid,
  output logic [A_W-1:0] upd_chan,
  output logic [C_W-1:0] upd_code
);
  // Line order in the synchronizer: [2]=sync, [1]=sclk, [0]=data
  logic [2:0] ln_cur, ln_prev;
  logic       fs_fall, sck_fall;
  logic       rx_armed;
  logic [N_CW-1:0] rx_cnt;

  dacbank_sync #(.W(3), .RST_VAL(3'b110)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({fs_n_in, sck_in, sdi_in}),
    .sync_out (ln_cur),
    .prev_out (ln_prev)
  );

  assign fs_fall  = ln_prev[2] & ~ln_cur[2];
  assign sck_fall = ln_prev[1] & ~ln_cur[1];

  dacbank_frame_rx #(.A_W(A_W), .C_W(C_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .fs_fall   (fs_fall),
    .sck_fall  (sck_fall),
    .sdi       (ln_cur[0]),
    .armed     (rx_armed),
    .bit_cnt   (rx_cnt),
    .frm_valid (upd_valid),
    .frm_chan  (upd_chan),
    .frm_code  (upd_code)
  );

  dacbank_code_bank #(.N_CH(N_CH), .C_W(C_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (upd_valid),
    .wr_chan (upd_chan),
    .wr_code (upd_code),
    .rd_chan (rd_chan),
    .rd_code (rd_code)
  );
endmodule

// File: rtl/dacbank_chk.sv
module dacbank_chk #(
  parameter int A_W  = 5,
  parameter int C_W  = 14,
  parameter int N_CW = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            fs_fall,
  input logic            sck_fall,
  input logic            rx_armed,
  input logic [N_CW-1:0] rx_cnt,
  input logic            upd_valid,
  input logic [A_W-1:0]  upd_chan,
  input logic [C_W-1:0]  upd_code,
  input logic [A_W-1:0]  rd_chan,
  input logic [C_W-1:0]  rd_code
);
  localparam int N_BITS = A_W + C_W;

  // R4: strobe is one cycle wide
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> !upd_valid);

  // R3: the written code is visible on the read port the cycle after the strobe
  a_r3_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(upd_valid) && rd_chan == $past(upd_chan)) |-> rd_code == $past(upd_code));

  // R5: with no armed frame and no falling sync, the interface stays idle
  a_r5_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_armed && !fs_fall) |=> (!rx_armed && !upd_valid));

  // R6: a sync edge during an armed frame does not end or restart it
  a_r6_sync_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_armed && fs_fall && !sck_fall) |=> (rx_armed && $stable(rx_cnt)));

  // R7: a completed frame leaves the interface disarmed
  a_r7_done_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> !rx_armed);

  // R2: the count never reaches the frame length while armed
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rx_armed |-> rx_cnt < N_CW'(N_BITS));
endmodule

bind dacbank_top dacbank_chk #(.A_W(A_W), .C_W(C_W), .N_CW(N_CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .fs_fall   (fs_fall),
  .sck_fall  (sck_fall),
  .rx_armed  (rx_armed),
  .rx_cnt    (rx_cnt),
  .upd_valid (upd_valid),
  .upd_chan  (upd_chan),
  .upd_code  (upd_code),
  .rd_chan   (rd_chan),
  .rd_code   (rd_code)
);

// File: tb/tb_dacbank_top.sv
`timescale 1ns/1ps
module tb_dacbank_top;
  localparam int NCH  = 32;
  localparam int CW   = 14;
  localparam int AW   = 5;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fs_n_in = 1'b1, sck_in = 1'b1, sdi_in = 1'b0;
  logic [AW-1:0] rd_chan = '0;
  logic [CW-1:0] rd_code;
  logic upd_valid;
  logic [AW-1:0] upd_chan;
  logic [CW-1:0] upd_code;

  int checks = 0, errors = 0;
  int pulses = 0, wide = 0;
  logic prev_v = 1'b0;
  logic [AW-1:0] last_ch;
  logic [CW-1:0] last_code;
  logic [CW-1:0] model [NCH];

  always #10 clk = ~clk;

  dacbank_top dut (.*);

  // strobe monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (upd_valid) begin
      pulses++;
      last_ch   = upd_chan;
      last_code = upd_code;
      if (prev_v) wide++;
    end
    prev_v = upd_valid;
  end

  function automatic logic [AW+CW-1:0] make_word(logic [AW-1:0] ch, logic [CW-1:0] cd);
    return {ch, cd};
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_bit(logic b);
    sdi_in = b; sck_in = 1'b1; tick(HALF);
    sck_in = 1'b0; tick(HALF);
    sck_in = 1'b1;
  endtask

  task automatic send_bits(logic [AW+CW-1:0] w, int hi, int lo);
    for (int i = hi; i >= lo; i--) send_bit(w[i]);
  endtask

  task automatic frame(logic [AW-1:0] ch, logic [CW-1:0] cd, int pre, int extra);
    logic [AW+CW-1:0] w;
    w = make_word(ch, cd);
    for (int i = 0; i < pre; i++) send_bit(1'($urandom));
    fs_n_in = 1'b0; tick(HALF);
    send_bits(w, AW+CW-1, 0);
    for (int i = 0; i < extra; i++) send_bit(1'($urandom));
    tick(2);
    fs_n_in = 1'b1; tick(6);
    model[ch] = cd;
  endtask

  task automatic check_all(string tag);
    for (int c = 0; c < NCH; c++) begin
      rd_chan = AW'(c); tick(1);
      chk(rd_code == model[c], tag, int'(rd_code), int'(model[c]));
    end
  endtask

  task automatic check_frame(string tag, int p0, logic [AW-1:0] ch, logic [CW-1:0] cd);
    chk(pulses == p0 + 1, {tag, " R4 pulse count"}, pulses - p0, 1);
    chk(last_ch == ch && last_code == cd, {tag, " R4 strobe payload"},
        int'({last_ch, last_code}), int'({ch, cd}));
    chk(wide == 0, {tag, " R4 strobe width"}, wide, 0);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int p0;
    logic [AW-1:0] ch;
    logic [CW-1:0] cd;
    logic [AW+CW-1:0] w;
    void'($urandom(32'd1234));
    for (int c = 0; c < NCH; c++) model[c] = '0;

    tick(5);
    chk(upd_valid == 1'b0, "R1 strobe low in reset", upd_valid, 0);
    rst_n = 1'b1; tick(4);
    check_all("R1 reset codes zero");

    // R5: clocks with no falling sync are ignored
    p0 = pulses;
    send_bits(make_word(5'd9, 14'h1ABC), AW+CW-1, 0);
    send_bits(make_word(5'd3, 14'h3FFF), AW+CW-1, 0);
    tick(6);
    chk(pulses == p0, "R5 no strobe without sync", pulses - p0, 0);
    check_all("R5 bank unchanged");

    // R2 corner: channel 0, all ones; channel 31, alternating
    p0 = pulses; frame(5'd0, 14'h3FFF, 0, 0);
    check_frame("R2 ch0", p0, 5'd0, 14'h3FFF);
    check_all("R3 ch0 write");
    p0 = pulses; frame(5'd31, 14'h2AAA, 0, 0);
    check_frame("R2 ch31", p0, 5'd31, 14'h2AAA);
    check_all("R3 ch31 write");

    // R6: sync toggles in the middle of a frame
    p0 = pulses;
    w = make_word(5'd17, 14'h0F0F);
    fs_n_in = 1'b0; tick(HALF);
    send_bits(w, AW+CW-1, 9);
    fs_n_in = 1'b1; tick(HALF); fs_n_in = 1'b0; tick(HALF);
    send_bits(w, 8, 0);
    tick(2); fs_n_in = 1'b1; tick(6);
    model[17] = 14'h0F0F;
    check_frame("R6 mid-frame sync", p0, 5'd17, 14'h0F0F);
    check_all("R6 bank");

    // R7: extra clocks after a full frame, with sync held low
    p0 = pulses;
    fs_n_in = 1'b0; tick(HALF);
    send_bits(make_word(5'd4, 14'h1234), AW+CW-1, 0);
    send_bits(make_word(5'd5, 14'h0777), AW+CW-1, 0);
    tick(2); fs_n_in = 1'b1; tick(6);
    model[4] = 14'h1234;
    check_frame("R7 extra clocks", p0, 5'd4, 14'h1234);
    check_all("R7 bank");
    p0 = pulses; frame(5'd5, 14'h0001, 0, 7);
    check_frame("R7 rearm", p0, 5'd5, 14'h0001);

    // R8: continuous clock around frames, and gated
    for (int k = 0; k < 40; k++) begin
      ch = AW'($urandom); cd = CW'($urandom);
      p0 = pulses;
      if (k % 2 == 0) frame(ch, cd, 1 + ($urandom % 4), $urandom % 4);
      else            frame(ch, cd, 0, 0);
      check_frame("R8 random frame", p0, ch, cd);
      rd_chan = ch; tick(1);
      chk(rd_code == cd, "R3 random readback", int'(rd_code), int'(cd));
    end
    check_all("R3 bank after random");

    // R9: read port follows index without a clock
    rd_chan = 5'd31; #1;
    chk(rd_code == model[31], "R9 comb read 31", int'(rd_code), int'(model[31]));
    rd_chan = 5'd0; #1;
    chk(rd_code == model[0], "R9 comb read 0", int'(rd_code), int'(model[0]));
    tick(1);

    // R1: reset in operation clears everything
    rst_n = 1'b0; tick(3);
    chk(upd_valid == 1'b0, "R1 strobe low in reset", upd_valid, 0);
    rst_n = 1'b1; tick(4);
    for (int c = 0; c < NCH; c++) model[c] = '0;
    check_all("R1 cleared after reset");
    p0 = pulses;
    send_bits(make_word(5'd7, 14'h2222), AW+CW-1, 0);
    tick(6);
    chk(pulses == p0, "R5 no strobe after reset", pulses - p0, 0);
    p0 = pulses; frame(5'd7, 14'h2222, 2, 0);
    check_frame("R5 frame after reset", p0, 5'd7, 14'h2222);
    check_all("R3 final bank");

    finish_run();
  end
endmodule